// File: doc/BRIEF.md
# Complex Normalizing Left Shifter with Sticky Overflow

This block sits at the output of a pipelined transform stage. It receives one complex sample per clock cycle, with signed real and imaginary parts that are three bits wider than the base data width `DATA_W`. It moves both parts left by 0, 1, 2 or 3 bit positions, as selected by a 2-bit shift code. It then keeps the low `DATA_W+2` bits of each part as the signed result. Because the result is narrower than the shifted value, a shift code that is too large for the current data loses significant bits. The block detects this loss on every sample and records it in a sticky flag.

The flag stays set until reset or until a frame-start pulse clears it. This lets the system that picks the shift code see whether any sample of a frame overflowed. The frame-start pulse also travels through the block with the same one-cycle delay as the data, so it stays aligned with the first result of the frame. When two of these blocks are chained, a 4-bit code is split between them: bits [1:0] drive the first block and bits [3:2] drive the second.

The sticky flag is held by a two-state machine. In `OVF_CLEAR` the flag reads 0. The transition `SET_ON_HIT` goes from `OVF_CLEAR` to `OVF_LATCHED` when a sample overflows while no frame start is present. In `OVF_LATCHED` the flag reads 1. The transition `CLEAR_ON_START` goes back to `OVF_CLEAR` on a frame-start pulse. Reset forces `OVF_CLEAR`. In all other cases the machine stays in its current state (`HOLD`).

Top module: `cplx_shift_norm`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, every output reads 0 after the clock edge, whatever the other inputs are.
- R2: One cycle after a sample is presented, `dout_re` and `dout_im` equal the low `DATA_W+2` bits of that sample's real and imaginary parts, each multiplied by 2 to the power of the shift code.
- R3: The shift code value k (0, 1, 2 or 3) selects a left shift of exactly k bits, and it is sampled in the same cycle as the data it applies to.
- R4: A part overflows when its shifted value lies outside the signed range of `DATA_W+2` bits, from -2^(DATA_W+1) to 2^(DATA_W+1)-1. The real and imaginary parts are tested independently, and an overflow in either one, with `frame_start` low, makes `ovf_flag` read 1 in the next cycle.
- R5: Once `ovf_flag` is 1, it stays 1 for as long as `frame_start` remains low, even when the samples that follow are in range.
- R6: `frame_start` high makes `ovf_flag` read 0 in the next cycle. This also holds when the sample presented in that same cycle overflows: the clear takes priority.
- R7: `frame_rdy` equals `frame_start` delayed by exactly one cycle.
- R8: An overflowing sample is not saturated. Its output is the truncated shifted value described in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Frame start pulse; clears the overflow flag |
| shift_code | input | 2 | Left shift amount, 0 to 3 |
| din_re | input | DATA_W+3 | Signed real part of the input sample |
| din_im | input | DATA_W+3 | Signed imaginary part of the input sample |
| frame_rdy | output | 1 | Frame start pulse delayed by one cycle |
| dout_re | output | DATA_W+2 | Signed real part of the result |
| dout_im | output | DATA_W+2 | Signed imaginary part of the result |
| ovf_flag | output | 1 | Sticky overflow indicator |

## Verification
Two functions of the block can fall in the same cycle: the clear driven by a frame-start pulse and the setting of the flag by an overflowing sample. The bench provokes this by presenting a sample that overflows by a single step, in the same cycle as `frame_start`, while the flag is already set. It expects the flag to read 0 in the next cycle and the truncated data to come out unchanged. Other cases show the opposite order: an overflow one cycle after a clear sets the flag again, and an overflow on the imaginary part alone sets it too.

// File: rtl/nrm_pkg.sv
package nrm_pkg;

    localparam int SHIFT_W   = 2;
    localparam int MAX_SHIFT = (1 << SHIFT_W) - 1;
    localparam int LANES     = 2;

    typedef enum logic [0:0] {
        OVF_CLEAR   = 1'b0,
        OVF_LATCHED = 1'b1
    } ovf_state_e;

endpackage

// File: rtl/nrm_shift_lane.sv
module nrm_shift_lane
    import nrm_pkg::*;
#(
    parameter int IN_W  = 13,
    parameter int OUT_W = 12
) (
    input  logic [IN_W-1:0]    din,
    input  logic [SHIFT_W-1:0] shift_code,
    output logic [OUT_W-1:0]   dout,
    output logic               ovf
);
    // The sample is sign-extended far enough that no shift of up to
    // MAX_SHIFT bits can push a significant bit off the top.
    localparam int EXT_W  = IN_W + MAX_SHIFT;
    localparam int HEAD_W = EXT_W - OUT_W + 1;

    logic [EXT_W-1:0]  ext;
    logic [EXT_W-1:0]  shifted;
    logic [HEAD_W-1:0] head;

    always_comb begin
        ext     = {{MAX_SHIFT{din[IN_W-1]}}, din};
        shifted = ext << shift_code;
        // head spans the output sign bit and every discarded bit above it
        head    = shifted[EXT_W-1:OUT_W-1];
        dout    = shifted[OUT_W-1:0];
        ovf     = !((&head) || !(|head));
    end

endmodule

// File: rtl/nrm_ovf_tracker.sv
module nrm_ovf_tracker
    import nrm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic hit,
    output logic flag
);
    ovf_state_e state_q;
    ovf_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OVF_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVF_CLEAR: begin
                if (hit && !clear) begin
                    state_d = OVF_LATCHED;   // SET_ON_HIT
                end
            end
            OVF_LATCHED: begin
                if (clear) begin
                    state_d = OVF_CLEAR;     // CLEAR_ON_START
                end
            end
            default: state_d = OVF_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q == OVF_LATCHED);
    end

endmodule

// File: rtl/cplx_shift_norm.sv
module cplx_shift_norm
    import nrm_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       frame_start,
    input  logic [1:0]                 shift_code,
    input  logic signed [DATA_W+2:0]   din_re,
    input  logic signed [DATA_W+2:0]   din_im,
    output logic                       frame_rdy,
    output logic signed [DATA_W+1:0]   dout_re,
    output logic signed [DATA_W+1:0]   dout_im,
    output logic                       ovf_flag
);
    localparam int IN_W  = DATA_W + 3;
    localparam int OUT_W = DATA_W + 2;

    logic [IN_W-1:0]  lane_in  [LANES];
    logic [OUT_W-1:0] lane_out [LANES];
    logic [LANES-1:0] lane_ovf;
    logic             any_ovf;

    assign lane_in[0] = din_re;
    assign lane_in[1] = din_im;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        nrm_shift_lane #(
            .IN_W  (IN_W),
            .OUT_W (OUT_W)
        ) u_lane (
            .din        (lane_in[g]),
            .shift_code (shift_code),
            .dout       (lane_out[g]),
            .ovf        (lane_ovf[g])
        );
    end

    assign any_ovf = |lane_ovf;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_re   <= '0;
            dout_im   <= '0;
            frame_rdy <= 1'b0;
        end else begin
            dout_re   <= lane_out[0];
            dout_im   <= lane_out[1];
            frame_rdy <= frame_start;
        end
    end

    nrm_ovf_tracker u_trk (
        .clk   (clk),
        .rst   (rst),
        .clear (frame_start),
        .hit   (any_ovf),
        .flag  (ovf_flag)
    );

endmodule

// File: rtl/cplx_shift_norm_chk.sv
module cplx_shift_norm_chk #(
    parameter int DATA_W = 10
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     frame_start,
    input logic [1:0]               shift_code,
    input logic signed [DATA_W+2:0] din_re,
    input logic signed [DATA_W+2:0] din_im,
    input logic                     frame_rdy,
    input logic signed [DATA_W+1:0] dout_re,
    input logic signed [DATA_W+1:0] dout_im,
    input logic                     ovf_flag
);
    localparam int IN_W  = DATA_W + 3;
    localparam int OUT_W = DATA_W + 2;
    localparam int EXT_W = IN_W + 3;
    localparam logic signed [EXT_W-1:0] LIM_HI = EXT_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [EXT_W-1:0] LIM_LO = -LIM_HI - 1;

    // Reference formed by multiplication and a range comparison,
    // rather than by shifting and testing the head bits.
    logic signed [EXT_W-1:0] scale;
    logic signed [EXT_W-1:0] prod_re;
    logic signed [EXT_W-1:0] prod_im;
    logic                    out_of_range;

    always_comb begin
        scale        = EXT_W'(1) << shift_code;
        prod_re      = EXT_W'(din_re) * scale;
        prod_im      = EXT_W'(din_im) * scale;
        out_of_range = (prod_re > LIM_HI) || (prod_re < LIM_LO) ||
                       (prod_im > LIM_HI) || (prod_im < LIM_LO);
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!frame_rdy && !ovf_flag && dout_re == '0 && dout_im == '0)); // R1
    AST_DATA_TRUNC_RE: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (dout_re == $past(prod_re[OUT_W-1:0]))); // R2
    AST_DATA_TRUNC_IM: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (dout_im == $past(prod_im[OUT_W-1:0]))); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (out_of_range && !frame_start) |=> ovf_flag); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) (ovf_flag && !frame_start) |=> ovf_flag); // R5
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst) frame_start |=> !ovf_flag); // R6
    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(ovf_flag) |-> $past(out_of_range)); // R4
    AST_RDY_DELAY: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (frame_rdy == $past(frame_start))); // R7

endmodule

bind cplx_shift_norm cplx_shift_norm_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .shift_code  (shift_code),
    .din_re      (din_re),
    .din_im      (din_im),
    .frame_rdy   (frame_rdy),
    .dout_re     (dout_re),
    .dout_im     (dout_im),
    .ovf_flag    (ovf_flag)
);

// File: tb/cplx_shift_norm_tb.sv
module cplx_shift_norm_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 10;
    localparam int IN_W       = DATA_W + 3;
    localparam int OUT_W      = DATA_W + 2;
    localparam int HI         = (1 << (OUT_W - 1)) - 1;
    localparam int LO         = -(1 << (OUT_W - 1));

    typedef struct {
        logic [OUT_W-1:0] re;
        logic [OUT_W-1:0] im;
        logic             rdy;
        logic             flag;
        string            tag;
    } exp_t;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     frame_start = 1'b0;
    logic [1:0]               shift_code = 2'd0;
    logic signed [IN_W-1:0]   din_re = '0;
    logic signed [IN_W-1:0]   din_im = '0;
    logic                     frame_rdy;
    logic signed [OUT_W-1:0]  dout_re;
    logic signed [OUT_W-1:0]  dout_im;
    logic                     ovf_flag;

    int   total = 0;
    int   bad   = 0;
    bit   model_flag = 1'b0;
    bit   finished = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    cplx_shift_norm #(.DATA_W(DATA_W)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .shift_code  (shift_code),
        .din_re      (din_re),
        .din_im      (din_im),
        .frame_rdy   (frame_rdy),
        .dout_re     (dout_re),
        .dout_im     (dout_im),
        .ovf_flag    (ovf_flag)
    );

    function automatic bit out_range(int v);
        return (v > HI) || (v < LO);
    endfunction

    // Driver: presents one sample and pushes the result expected after the next edge.
    task automatic drive(int re, int im, int sh, bit st, string tag);
        exp_t  e;
        int    vr;
        int    vi;
        logic [31:0] ur;
        logic [31:0] ui;
        @(negedge clk);
        frame_start = st;
        shift_code  = 2'(sh);
        din_re      = IN_W'(re);
        din_im      = IN_W'(im);
        vr = re * (1 << sh);
        vi = im * (1 << sh);
        ur = vr;
        ui = vi;
        if (st) model_flag = 1'b0;
        else if (out_range(vr) || out_range(vi)) model_flag = 1'b1;
        e.re   = ur[OUT_W-1:0];
        e.im   = ui[OUT_W-1:0];
        e.rdy  = st;
        e.flag = model_flag;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compares each result shortly after the edge that produced it.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                total++;
                if (dout_re !== e.re || dout_im !== e.im ||
                    frame_rdy !== e.rdy || ovf_flag !== e.flag) begin
                    bad++;
                    $display("FAIL %s: got re=%h im=%h rdy=%b ovf=%b expected re=%h im=%h rdy=%b ovf=%b",
                             e.tag, dout_re, dout_im, frame_rdy, ovf_flag,
                             e.re, e.im, e.rdy, e.flag);
                end
            end
        end
    end

    task automatic check_reset();
        @(posedge clk);
        #2;
        total++;
        if (dout_re !== '0 || dout_im !== '0 || frame_rdy !== 1'b0 || ovf_flag !== 1'b0) begin
            bad++;
            $display("FAIL R1: got re=%h im=%h rdy=%b ovf=%b expected all zero",
                     dout_re, dout_im, frame_rdy, ovf_flag);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset holds outputs at zero even with live inputs
        @(negedge clk);
        din_re = 13'sd700;
        din_im = -13'sd300;
        shift_code = 2'd3;
        frame_start = 1'b1;
        check_reset();
        check_reset();
        check_reset();
        @(negedge clk);
        rst = 1'b0;
        frame_start = 1'b0;
        din_re = '0;
        din_im = '0;
        shift_code = 2'd0;

        // R7: framing pulse delayed one cycle; R2/R3 with shift 0
        drive(0, 0, 0, 1'b1, "R7 start");
        drive(123, -45, 0, 1'b0, "R2 R3 shift0");
        drive(HI, LO, 0, 1'b0, "R4 shift0 edges in range");
        drive(-7, 9, 1, 1'b0, "R3 shift1");
        drive(HI / 2, LO / 2, 1, 1'b0, "R4 shift1 edges in range");
        drive(300, -250, 2, 1'b0, "R3 shift2");
        drive(HI / 4, LO / 4, 2, 1'b0, "R4 shift2 edges in range");
        drive(-256, 255, 3, 1'b0, "R3 shift3 edges in range");

        // R4/R8: overflow by one step on the real part, shift 1
        drive(1024, 0, 1, 1'b0, "R4 R8 real overflow shift1");
        // R5: in-range samples keep the flag
        drive(1, 1, 0, 1'b0, "R5 sticky");
        drive(-2, 3, 2, 1'b0, "R5 sticky");
        drive(0, 0, 3, 1'b0, "R5 sticky");

        // R6: clear with a simultaneously overflowing sample
        drive(-257, 0, 3, 1'b1, "R6 clear wins");
        drive(5, 5, 0, 1'b0, "R6 stays clear");
        // R4: imaginary-only overflow, negative side, shift 2
        drive(0, -513, 2, 1'b0, "R4 imag overflow");
        drive(0, 0, 0, 1'b1, "R6 clear");
        // R8: shift 0 max positive wraps, no saturation
        drive(4095, -4096, 0, 1'b0, "R8 wrap shift0");
        drive(0, 0, 0, 1'b1, "R6 clear");
        drive(HI, 0, 0, 1'b0, "R4 boundary no overflow");

        // mixed patterns across all shift codes
        for (int i = 0; i < 200; i++) begin
            int r;
            int m;
            int s;
            r = int'($urandom_range(0, 8191)) - 4096;
            m = int'($urandom_range(0, 8191)) - 4096;
            s = int'($urandom_range(0, 3));
            if (i % 4 == 0) begin
                r = r / 16;
                m = m / 16;
            end
            drive(r, m, s, (i % 23) == 0, "R2 R4 R5 R6 mixed");
        end

        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule